// File: doc/BRIEF.md
# Pipelined Instruction Fetch Master

This block fetches 16-bit instruction words for a CPU pipeline over a read-only bus port whose slaves may answer after a variable number of cycles. It never writes. It posts read requests back to back, each address two bytes past the previous one, and keeps several reads in flight before their data returns. Straight-line flow is the fixed prediction, so branches are treated as not taken.

The pipeline tells the block of a taken branch or other change of flow with a one-cycle redirect pulse and a target address. The block then restarts issuing at the target, empties its output buffer, and silently drops every response that belongs to a read accepted on the old path. Returned words go through a small buffer to an instruction output with valid and ready, each word tagged with its byte address, so backpressure never loses data. After reset the first fetch is at a configured base address plus a configured byte offset.

Top module: `ifetch_master`

## Requirements
- R1: After reset release the first read is presented at RESET_BASE + RESET_OFFSET, with insn_valid_o low until data has come back.
- R2: Absent a redirect, each accepted read (bus_read_o high, bus_wait_i low at a rising edge) is followed by a read at the accepted address plus 2.
- R3: While bus_read_o is high and bus_wait_i is high, bus_read_o stays high and bus_addr_o is unchanged in the next cycle.
- R4: At most MAX_PENDING reads are accepted and still waiting for bus_rvalid_i; at that limit no further read is presented.
- R5: Delivered words leave in fetch order, each with its byte address on insn_addr_o; while insn_valid_o is high and insn_ready_i low, the word and address hold.
- R6: When redir_i is high and no read is stalled by bus_wait_i, the next presented read is at redir_addr_i; the buffered words are discarded in that cycle and the next word delivered carries the target address.
- R7: Every response to a read accepted at or before the redirect edge is dropped, including a bus_rvalid_i beat in the very cycle of redir_i.
- R8: A read is presented only while accepted-but-unreturned reads plus buffered words are fewer than FIFO_DEPTH; with insn_ready_i held low the block stops issuing with the buffer full.
- R9: A read stalled by bus_wait_i when redir_i arrives keeps its old address until accepted; its data is dropped and the following read is at the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_o | output | ADDR_W | Read byte address |
| bus_read_o | output | 1 | Read request |
| bus_wait_i | input | 1 | Slave stalls the presented request |
| bus_rdata_i | input | 16 | Returned instruction word |
| bus_rvalid_i | input | 1 | Returned word valid, one per accepted read, in order |
| redir_i | input | 1 | Redirect pulse from the pipeline |
| redir_addr_i | input | ADDR_W | Redirect target byte address (even) |
| insn_o | output | 16 | Instruction word to the pipeline |
| insn_addr_o | output | ADDR_W | Byte address of insn_o |
| insn_valid_o | output | 1 | insn_o is valid |
| insn_ready_i | input | 1 | Pipeline takes insn_o |

## Verification
The assertions take for granted that the slave answers each accepted read exactly once, in acceptance order, and never raises bus_rvalid_i with no read outstanding; the bench memory model keeps a queue of accepted addresses with non-decreasing due cycles and returns at most one beat per cycle from its head. Redirect targets are assumed even, and the bench draws them only from even constants. Stall, latency and ready patterns are drawn at random inside those limits, with directed cases for the redirect that lands on a response beat and the redirect that meets a stalled request.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  localparam int unsigned INSN_BYTES = 2;
  localparam int unsigned INSN_W     = 16;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned ptr_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ifetch_addr_gen.sv
module ifetch_addr_gen
  import ifetch_pkg::*;
#(
  parameter int unsigned    ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              can_issue_i,
  input  logic              wait_i,
  input  logic              redir_i,
  input  logic [ADDR_W-1:0] redir_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              read_o,
  output logic              acc_o,
  output logic              stale_acc_o
);
  logic [ADDR_W-1:0] addr_q, tgt_q;
  logic              hold_stale_q;
  logic              stalled;

  assign read_o      = can_issue_i;
  assign addr_o      = addr_q;
  assign acc_o       = read_o & ~wait_i;
  assign stalled     = read_o & wait_i;
  assign stale_acc_o = acc_o & hold_stale_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q       <= RESET_ADDR;
      tgt_q        <= RESET_ADDR;
      hold_stale_q <= 1'b0;
    end else if (redir_i) begin
      if (stalled) begin
        // request must stay on the bus; remember where to go afterwards
        hold_stale_q <= 1'b1;
        tgt_q        <= redir_addr_i;
      end else begin
        hold_stale_q <= 1'b0;
        addr_q       <= redir_addr_i;
      end
    end else if (acc_o) begin
      if (hold_stale_q) begin
        addr_q       <= tgt_q;
        hold_stale_q <= 1'b0;
      end else begin
        addr_q <= addr_q + ADDR_W'(INSN_BYTES);
      end
    end
  end

  a_r3_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_o && wait_i) |=> (read_o && $stable(addr_o)));

  a_r2_seq_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && !redir_i && !hold_stale_q) |=> (addr_o == $past(addr_o) + ADDR_W'(INSN_BYTES)));

  a_r6_redir_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_i && !(read_o && wait_i)) |=> (addr_o == $past(redir_addr_i)));

  a_r9_held_then_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_stale_q && acc_o && !redir_i) |=> (addr_o == $past(tgt_q)));
endmodule

// File: rtl/ifetch_credit.sv
module ifetch_credit
  import ifetch_pkg::*;
#(
  parameter int unsigned MAX_PENDING = 4,
  parameter int unsigned FIFO_DEPTH  = 4,
  localparam int unsigned CNT_W = cnt_width(MAX_PENDING),
  localparam int unsigned FC_W  = cnt_width(FIFO_DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_i,
  input  logic            stale_acc_i,
  input  logic            beat_i,
  input  logic            redir_i,
  input  logic [FC_W-1:0] fifo_cnt_i,
  output logic            can_issue_o,
  output logic            push_o
);
  localparam int unsigned SUM_W = ((CNT_W > FC_W) ? CNT_W : FC_W) + 1;

  logic [CNT_W-1:0] pend_q, disc_q, pend_n, disc_n;
  logic [SUM_W-1:0] used;
  logic             drop;

  assign used        = SUM_W'(pend_q) + SUM_W'(fifo_cnt_i);
  assign can_issue_o = (pend_q < CNT_W'(MAX_PENDING)) && (used < SUM_W'(FIFO_DEPTH));
  assign drop        = beat_i & (redir_i | (disc_q != '0));
  assign push_o      = beat_i & ~drop;
  assign pend_n      = pend_q + CNT_W'(acc_i) - CNT_W'(beat_i);

  always_comb begin
    if (redir_i) begin
      // everything still outstanding after this edge is old-path
      disc_n = pend_n;
    end else begin
      disc_n = disc_q - CNT_W'(beat_i && (disc_q != '0)) + CNT_W'(stale_acc_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      disc_q <= '0;
    end else begin
      pend_q <= pend_n;
      disc_q <= disc_n;
    end
  end

  a_r4_pend_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= CNT_W'(MAX_PENDING));

  a_r7_disc_within_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_q <= pend_q);

  a_r7_redir_beat_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_i && beat_i) |-> !push_o);

  a_r8_room_for_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    can_issue_o |-> (fifo_cnt_i < FC_W'(FIFO_DEPTH)));
endmodule

// File: rtl/ifetch_fifo.sv
module ifetch_fifo
  import ifetch_pkg::*;
#(
  parameter int unsigned W     = 48,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned FC_W  = cnt_width(DEPTH),
  localparam int unsigned PTR_W = ptr_width(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            push_i,
  input  logic [W-1:0]    wdata_i,
  input  logic            pop_i,
  output logic [W-1:0]    rdata_o,
  output logic            valid_o,
  output logic [FC_W-1:0] cnt_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [FC_W-1:0]  cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign valid_o = (cnt_q != '0);
  assign rdata_o = mem_q[rd_q];
  assign cnt_o   = cnt_q;
  assign do_push = push_i & ~flush_i;
  assign do_pop  = pop_i & valid_o & ~flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wrap_inc(wr_q);
      if (do_pop)  rd_q <= wrap_inc(rd_q);
      cnt_q <= cnt_q + FC_W'(do_push) - FC_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |-> (cnt_q < FC_W'(DEPTH)));

  a_r5_hold_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i && !flush_i) |=> (valid_o && $stable(rdata_o)));

  a_r6_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_o);
endmodule

// File: rtl/ifetch_master.sv
module ifetch_master
  import ifetch_pkg::*;
#(
  parameter int unsigned       ADDR_W       = 32,
  parameter int unsigned       MAX_PENDING  = 4,
  parameter int unsigned       FIFO_DEPTH   = 4,
  parameter logic [ADDR_W-1:0] RESET_BASE   = 32'h0000_0400,
  parameter logic [ADDR_W-1:0] RESET_OFFSET = 32'h0000_0020
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_read_o,
  input  logic              bus_wait_i,
  input  logic [15:0]       bus_rdata_i,
  input  logic              bus_rvalid_i,
  input  logic              redir_i,
  input  logic [ADDR_W-1:0] redir_addr_i,
  output logic [15:0]       insn_o,
  output logic [ADDR_W-1:0] insn_addr_o,
  output logic              insn_valid_o,
  input  logic              insn_ready_i
);
  localparam logic [ADDR_W-1:0] RESET_ADDR = RESET_BASE + RESET_OFFSET;
  localparam int unsigned       ENT_W      = ADDR_W + INSN_W;
  localparam int unsigned       FC_W       = cnt_width(FIFO_DEPTH);

  generate
    if (FIFO_DEPTH < MAX_PENDING) begin : g_bad_cfg
      $error("FIFO_DEPTH must be at least MAX_PENDING");
    end
  endgenerate

  logic              can_issue, acc, stale_acc, push, pop;
  logic [FC_W-1:0]   fifo_cnt;
  logic [ENT_W-1:0]  head;
  logic [ADDR_W-1:0] ret_pc_q;

  ifetch_addr_gen #(
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR)
  ) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .can_issue_i  (can_issue),
    .wait_i       (bus_wait_i),
    .redir_i      (redir_i),
    .redir_addr_i (redir_addr_i),
    .addr_o       (bus_addr_o),
    .read_o       (bus_read_o),
    .acc_o        (acc),
    .stale_acc_o  (stale_acc)
  );

  ifetch_credit #(
    .MAX_PENDING (MAX_PENDING),
    .FIFO_DEPTH  (FIFO_DEPTH)
  ) u_credit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .stale_acc_i (stale_acc),
    .beat_i      (bus_rvalid_i),
    .redir_i     (redir_i),
    .fifo_cnt_i  (fifo_cnt),
    .can_issue_o (can_issue),
    .push_o      (push)
  );

  // address of the next word that will be kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ret_pc_q <= RESET_ADDR;
    else if (redir_i) ret_pc_q <= redir_addr_i;
    else if (push)    ret_pc_q <= ret_pc_q + ADDR_W'(INSN_BYTES);
  end

  assign pop = insn_valid_o & insn_ready_i;

  ifetch_fifo #(
    .W     (ENT_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (redir_i),
    .push_i  (push),
    .wdata_i ({ret_pc_q, bus_rdata_i}),
    .pop_i   (pop),
    .rdata_o (head),
    .valid_o (insn_valid_o),
    .cnt_o   (fifo_cnt)
  );

  assign insn_o      = head[INSN_W-1:0];
  assign insn_addr_o = head[ENT_W-1:INSN_W];

  a_r1_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!insn_valid_o));

  a_r5_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !redir_i && $past(insn_valid_o && insn_ready_i && !redir_i)) |->
      (insn_addr_o == $past(insn_addr_o) + ADDR_W'(INSN_BYTES)) || $past(push) || !$past(insn_valid_o));
endmodule

// File: tb/ifetch_master_bench.sv
`timescale 1ns/1ps
module ifetch_master_bench;
  localparam int          MAX_PEND = 4;
  localparam int          FIFO_D   = 4;
  localparam logic [31:0] RST_ADDR = 32'h0000_0420;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr, redir_addr = '0, insn_addr;
  logic        bus_read, bus_wait = 1'b0, bus_rvalid = 1'b0, redir = 1'b0;
  logic [15:0] bus_rdata = '0, insn;
  logic        insn_valid, insn_ready = 1'b0;

  always #5 clk = ~clk;

  ifetch_master u_ifetch_master (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bus_addr_o   (bus_addr),
    .bus_read_o   (bus_read),
    .bus_wait_i   (bus_wait),
    .bus_rdata_i  (bus_rdata),
    .bus_rvalid_i (bus_rvalid),
    .redir_i      (redir),
    .redir_addr_i (redir_addr),
    .insn_o       (insn),
    .insn_addr_o  (insn_addr),
    .insn_valid_o (insn_valid),
    .insn_ready_i (insn_ready)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;

  // stimulus controls
  int wait_pct = 0, ready_pct = 100, lat_min = 1, lat_max = 1;
  bit force_wait = 1'b0, redir_req = 1'b0, redir_on_beat = 1'b0;
  logic [31:0] redir_tgt = '0;

  // memory model and scoreboard state
  logic [31:0] mq_addr[$];
  int          mq_due[$];
  int          last_due = 0, outstanding = 0, max_out = 0, delivered = 0;
  logic [31:0] exp_issue = RST_ADDR, exp_pc = RST_ADDR, held_addr = '0, prev_addr = '0;
  bit          held_stale = 1'b0, prev_rw = 1'b0;
  int          held_hits = 0, beat_redirs = 0;

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit w, rv, r, acc, rdy;
      logic [15:0] d;
      cyc++;
      if (prev_rw) check(bus_read && bus_addr == prev_addr, "R3", "stalled request moved", bus_addr, prev_addr);

      w  = force_wait || ($urandom_range(99) < wait_pct);
      rv = 1'b0;
      d  = '0;
      if (mq_due.size() > 0 && mq_due[0] <= cyc) begin
        rv = 1'b1;
        d  = mem_word(mq_addr.pop_front());
        void'(mq_due.pop_front());
        outstanding--;
      end

      r = 1'b0;
      if (redir_req && (!redir_on_beat || rv)) begin
        r = 1'b1;
        redir_req = 1'b0;
        if (rv) beat_redirs++;
      end

      acc = bus_read && !w;
      if (acc) begin
        int due;
        if (held_stale) begin
          check(bus_addr == held_addr, "R9", "held request address", bus_addr, held_addr);
          held_stale = 1'b0;
        end else begin
          check(bus_addr == exp_issue, "R2", "issue address (R6 after redirect)", bus_addr, exp_issue);
          exp_issue += 2;
        end
        due = cyc + int'($urandom_range(lat_max, lat_min));
        if (due <= last_due) due = last_due + 1;
        last_due = due;
        mq_addr.push_back(bus_addr);
        mq_due.push_back(due);
        outstanding++;
        if (outstanding > max_out) max_out = outstanding;
        check(outstanding <= MAX_PEND, "R4", "outstanding reads", outstanding, MAX_PEND);
      end

      if (r) begin
        if (bus_read && w) begin
          held_stale = 1'b1;
          held_addr  = bus_addr;
          held_hits++;
        end
        exp_issue = redir_tgt;
        exp_pc    = redir_tgt;
      end

      rdy = ($urandom_range(99) < ready_pct);
      if (insn_valid && rdy && !r) begin
        check(insn_addr == exp_pc, "R5", "delivered address (R7 after redirect)", insn_addr, exp_pc);
        check(insn == mem_word(exp_pc), "R5", "delivered word", {16'h0, insn}, {16'h0, mem_word(exp_pc)});
        exp_pc += 2;
        delivered++;
      end

      prev_rw    = bus_read && w;
      prev_addr  = bus_addr;
      bus_wait   = w;
      bus_rvalid = rv;
      bus_rdata  = d;
      redir      = r;
      redir_addr = redir_tgt;
      insn_ready = rdy;
    end
  end

  always @(posedge clk) begin
    if (!finished && cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic redirect(input logic [31:0] tgt, input bit on_beat);
    redir_tgt     = tgt;
    redir_on_beat = on_beat;
    redir_req     = 1'b1;
    while (redir_req) @(posedge clk);
  endtask

  initial begin
    cycles(3);
    @(negedge clk);
    // R1: before the first edge out of reset
    check(!insn_valid, "R1", "valid low in reset", {31'h0, insn_valid}, 32'h0);
    check(bus_addr == RST_ADDR, "R1", "reset address", bus_addr, RST_ADDR);
    rst_n = 1'b1;
    #1;
    check(bus_read, "R1", "read presented after reset", {31'h0, bus_read}, 32'h1);

    // zero wait, single-cycle latency
    cycles(60);

    // long latency: pending limit reached
    lat_min = 8; lat_max = 8;
    cycles(60);
    check(max_out == MAX_PEND, "R4", "peak outstanding", max_out, MAX_PEND);

    // random stalls, latency and ready
    wait_pct = 30; lat_min = 1; lat_max = 5; ready_pct = 60;
    cycles(400);

    // backpressure fills the buffer
    ready_pct = 0; wait_pct = 0;
    cycles(40);
    @(negedge clk); #1;
    check(!bus_read, "R8", "issue stopped when full", {31'h0, bus_read}, 32'h0);
    check(outstanding == 0, "R8", "no reads in flight when full", outstanding, 0);
    check(insn_valid, "R5", "word held under backpressure", {31'h0, insn_valid}, 32'h1);
    ready_pct = 100;
    cycles(20);

    // plain redirects with traffic in flight
    lat_min = 2; lat_max = 6; wait_pct = 20; ready_pct = 70;
    for (int i = 0; i < 20; i++) begin
      cycles(5 + i % 7);
      redirect(32'h0000_1000 + 32'(i) * 32'h40, 1'b0);
    end
    cycles(40);

    // redirect landing on a response beat
    for (int i = 0; i < 10; i++) begin
      cycles(6);
      redirect(32'h0000_3000 + 32'(i) * 32'h80, 1'b1);
    end
    cycles(40);
    check(beat_redirs >= 10, "R7", "redirects on a beat", beat_redirs, 10);

    // redirect meeting a stalled request
    ready_pct = 100; wait_pct = 0; lat_min = 1; lat_max = 2;
    for (int i = 0; i < 6; i++) begin
      cycles(8);
      force_wait = 1'b1;
      cycles(3);
      redirect(32'h0000_5000 + 32'(i) * 32'h100, 1'b0);
      cycles(2);
      force_wait = 1'b0;
    end
    cycles(40);
    check(held_hits >= 1, "R9", "redirects during a stall", held_hits, 1);

    check(delivered >= 200, "R6", "words delivered overall", delivered, 200);
    check(outstanding <= MAX_PEND, "R4", "final outstanding", outstanding, MAX_PEND);
    summary();
  end
endmodule